// File: doc/BRIEF.md
# Secure memory region size filter

This block guards a small set of on-chip memories against non-secure bus masters. Each memory has a region-size register. The register splits the memory at a page boundary: the lower part, counted in 4 KiB pages from the memory base, is secure, and everything above it is non-secure. Only two attributes exist, so there is no read-only split. A secure access may touch any address in the memory. A non-secure access is stopped if its page lies inside the secure part.

A stopped access never reaches the memory. If it was a read it returns zero, and the error output pulses in the cycle after the request. Every region-size register also has a sticky lock bit. Once the lock is set, the size field is frozen until reset. A read-only configuration word tells software how many regions the block has.

The access path is a three-state machine:
- `ST_IDLE`: no result is pending.
- `ST_RD_PASS`: a granted read is pending, and the memory's read data is passed through.
- `ST_BLOCK`: a denied access is pending, and the error output is high.

On every clock the state moves as follows:
- To `ST_BLOCK` when a denied request is present, whatever the current state.
- To `ST_RD_PASS` when a granted read is present.
- To `ST_IDLE` when there is no request, or when a granted write is present.

Top module: `secmem_size_filter`

## Requirements
- R1: After reset, every region's size field and lock bit are zero, and every region register reads as zero.
- R2: Region i's register sits at byte offset 4*i. The secure page count is in bits 9:0 and the lock bit is bit 31. Bits 30:10 read as zero. Unmapped offsets read as zero.
- R3: The word at byte offset 0x3F0 reads the number of regions in bits 7:0 and zero elsewhere. Writes to it have no effect.
- R4: Writing a 1 to bit 31 sets that region's lock. Writing a 0 there never clears it before reset.
- R5: While a region is locked, writes to its size field are ignored. A write that sets the lock on an unlocked region also loads the size written with it.
- R6: A non-secure access (acc_nonsec=1) whose page, offset bits 21:12, is below the region's size is denied. In the request cycle mem_en and mem_we stay low. In the next cycle acc_err is 1 for one cycle and acc_rdata is zero.
- R7: A non-secure access whose page is at or above the region's size is granted. mem_en is 1, and mem_we equals acc_write, both in the request cycle. acc_err stays 0.
- R8: A secure access (acc_nonsec=0) is granted at every offset, whatever the size.
- R9: In the cycle after a granted read, acc_rdata equals mem_rdata. At all other times it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| acc_valid | input | 1 | Memory access request |
| acc_region | input | 1 | Index of the target memory |
| acc_offset | input | 22 | Byte offset within the target memory |
| acc_nonsec | input | 1 | 1 for a non-secure access |
| acc_write | input | 1 | 1 for a write |
| mem_en | output | 1 | Access forwarded to the memory |
| mem_we | output | 1 | Forwarded write enable |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_en |
| acc_rdata | output | 32 | Filtered read data back to the requester |
| acc_err | output | 1 | Denied-access error pulse |

## Verification
The assertions assume the following about the inputs:
- acc_region always names an existing region.
- The memory returns its read data exactly one cycle after mem_en.
- The access inputs are stable around each clock edge.

The bench drives every input on the falling edge and only uses valid region indices. It presents mem_rdata in the cycle after each request. For several size settings it sweeps every page of both regions, in secure and non-secure mode, with reads and writes interleaved. Its expected grant and data values come from comparing the page against the size it programmed.

// File: rtl/secmem_pkg.sv
package secmem_pkg;
    // Access-path states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_PASS = 2'd1,
        ST_BLOCK   = 2'd2
    } acc_state_e;

    localparam int REG_AW    = 10;
    localparam int LOCK_BIT  = 31;
    localparam logic [7:0] CFG_WORD = 8'hFC; // byte offset 0x3F0
endpackage

// File: rtl/secmem_region_bank.sv
module secmem_region_bank #(
    parameter int NUM_REGIONS = 2,
    parameter int SIZE_W      = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_word,
    input  logic [31:0]                   wr_data,
    output logic [NUM_REGIONS*SIZE_W-1:0] size_flat,
    output logic [NUM_REGIONS-1:0]        lock_vec
);
    import secmem_pkg::*;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
        logic              hit;
        logic [SIZE_W-1:0] size_q;
        logic              lock_q;

        assign hit = wr_en && (wr_word == 8'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                size_q <= '0;
                lock_q <= 1'b0;
            end else if (hit) begin
                if (!lock_q) size_q <= wr_data[SIZE_W-1:0];
                lock_q <= lock_q | wr_data[LOCK_BIT];
            end
        end

        assign size_flat[i*SIZE_W +: SIZE_W] = size_q;
        assign lock_vec[i] = lock_q;

        a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q |=> lock_q);
        a_r5_locked_size_hold: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q |=> $stable(size_q));
    end
endmodule

// File: rtl/secmem_judge.sv
module secmem_judge #(
    parameter int NUM_REGIONS = 2,
    parameter int SIZE_W      = 10,
    parameter int PAGE_SHIFT  = 12,
    parameter int OFFSET_W    = 22,
    parameter int RIDX_W      = 1
) (
    input  logic [NUM_REGIONS*SIZE_W-1:0] size_flat,
    input  logic [RIDX_W-1:0]             region,
    input  logic [OFFSET_W-1:0]           offset,
    input  logic                          nonsec,
    output logic                          allow
);
    localparam int PG_W = OFFSET_W - PAGE_SHIFT;

    logic [SIZE_W-1:0] sel_size;
    logic [PG_W-1:0]   page;
    logic              in_secure;

    always_comb begin
        sel_size = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (region == RIDX_W'(i)) sel_size = size_flat[i*SIZE_W +: SIZE_W];
        end
    end

    assign page      = offset[OFFSET_W-1:PAGE_SHIFT];
    assign in_secure = 32'(page) < 32'(sel_size);
    assign allow     = !nonsec || !in_secure;
endmodule

// File: rtl/secmem_access_fsm.sv
module secmem_access_fsm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        write,
    input  logic        allow,
    input  logic [31:0] mem_rdata,
    output logic [31:0] rdata,
    output logic        err
);
    import secmem_pkg::*;

    acc_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (req) begin
            if (!allow)     state_d = ST_BLOCK;
            else if (!write) state_d = ST_RD_PASS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rdata = '0;
        err   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RD_PASS: rdata = mem_rdata;
            ST_BLOCK:   err   = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/secmem_size_filter.sv
module secmem_size_filter #(
    parameter int NUM_REGIONS = 2,
    parameter int SIZE_W      = 10,
    parameter int PAGE_SHIFT  = 12,
    parameter int OFFSET_W    = PAGE_SHIFT + SIZE_W,
    parameter int RIDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [9:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                acc_valid,
    input  logic [RIDX_W-1:0]   acc_region,
    input  logic [OFFSET_W-1:0] acc_offset,
    input  logic                acc_nonsec,
    input  logic                acc_write,
    output logic                mem_en,
    output logic                mem_we,
    input  logic [31:0]         mem_rdata,
    output logic [31:0]         acc_rdata,
    output logic                acc_err
);
    import secmem_pkg::*;

    logic [NUM_REGIONS*SIZE_W-1:0] size_flat;
    logic [NUM_REGIONS-1:0]        lock_vec;
    logic [7:0]                    word;
    logic                          allow;

    assign word = reg_addr[REG_AW-1:2];

    secmem_region_bank #(.NUM_REGIONS(NUM_REGIONS), .SIZE_W(SIZE_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_word  (word),
        .wr_data  (reg_wdata),
        .size_flat(size_flat),
        .lock_vec (lock_vec)
    );

    always_comb begin
        reg_rdata = '0;
        if (word == CFG_WORD) begin
            reg_rdata[7:0] = 8'(NUM_REGIONS);
        end else begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                if (word == 8'(i)) begin
                    reg_rdata[SIZE_W-1:0] = size_flat[i*SIZE_W +: SIZE_W];
                    reg_rdata[LOCK_BIT]   = lock_vec[i];
                end
            end
        end
    end

    secmem_judge #(
        .NUM_REGIONS(NUM_REGIONS), .SIZE_W(SIZE_W), .PAGE_SHIFT(PAGE_SHIFT),
        .OFFSET_W(OFFSET_W), .RIDX_W(RIDX_W)
    ) u_judge (
        .size_flat(size_flat),
        .region   (acc_region),
        .offset   (acc_offset),
        .nonsec   (acc_nonsec),
        .allow    (allow)
    );

    assign mem_en = acc_valid && allow;
    assign mem_we = mem_en && acc_write;

    secmem_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (acc_valid),
        .write    (acc_write),
        .allow    (allow),
        .mem_rdata(mem_rdata),
        .rdata    (acc_rdata),
        .err      (acc_err)
    );

    a_r8_secure_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_nonsec) |-> mem_en);
    a_r6_err_after_denied: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> ($past(acc_valid) && !$past(mem_en)));
    a_r6_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_rdata == 32'd0));
    a_r7_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);
    a_r9_data_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rdata != 32'd0) |-> ($past(mem_en) && !$past(acc_write)));
endmodule

// File: tb/tb_secmem_size_filter.sv
module tb_secmem_size_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [0:0]  acc_region = '0;
    logic [21:0] acc_offset = '0;
    logic        acc_nonsec = 1'b0;
    logic        acc_write = 1'b0;
    logic        mem_en, mem_we;
    logic [31:0] mem_rdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;

    int checks = 0;
    int errors = 0;
    int sz [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    secmem_size_filter dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_region(acc_region), .acc_offset(acc_offset), .acc_nonsec(acc_nonsec),
        .acc_write(acc_write), .mem_en(mem_en), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .acc_rdata(acc_rdata), .acc_err(acc_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read_check(input logic [9:0] a, input logic [31:0] exp,
                                  input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic access(input int reg_i, input int page, input bit ns, input bit wr);
        bit          exp_allow;
        logic [31:0] pat;
        bit          ok;
        exp_allow = !ns || (page >= sz[reg_i]);
        pat = 32'hA500_0000 | 32'(page) | (32'(reg_i) << 16);
        @(negedge clk);
        acc_valid = 1'b1; acc_region = 1'(reg_i); acc_nonsec = ns; acc_write = wr;
        acc_offset = 22'((page << 12) | ((page * 7) & 12'hFFF));
        #1;
        // R6 R7 R8: grant decision in the request cycle
        ok = (mem_en == exp_allow) && (mem_we == (exp_allow && wr));
        check(ok, ns ? (exp_allow ? "R7" : "R6") : "R8",
              {30'd0, mem_en, mem_we}, {30'd0, exp_allow, exp_allow && wr});
        @(negedge clk);
        acc_valid = 1'b0; mem_rdata = pat;
        #1;
        // R6 R9: error pulse and filtered data in the following cycle
        check(acc_err == !exp_allow, "R6", {31'd0, acc_err}, {31'd0, !exp_allow});
        check(acc_rdata == ((exp_allow && !wr) ? pat : 32'd0), "R9", acc_rdata,
              (exp_allow && !wr) ? pat : 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int sizes [5] = '{0, 1, 37, 512, 1023};
        sz[0] = 0; sz[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_read_check(10'h000, 32'd0, "R1");
        reg_read_check(10'h004, 32'd0, "R1");
        // R3 configuration word, write ignored
        reg_read_check(10'h3F0, 32'd2, "R3");
        reg_write(10'h3F0, 32'hFFFF_FFFF);
        reg_read_check(10'h3F0, 32'd2, "R3");
        reg_read_check(10'h000, 32'd0, "R3");
        // R2 field layout and unmapped offsets
        reg_write(10'h000, 32'h7FFF_FC05);
        reg_read_check(10'h000, 32'd5, "R2");
        reg_read_check(10'h100, 32'd0, "R2");
        reg_write(10'h004, 32'd300);
        reg_read_check(10'h004, 32'd300, "R2");
        // sweep of sizes, all pages, both regions and security modes
        foreach (sizes[k]) begin
            sz[0] = sizes[k];
            sz[1] = 1023 - sizes[k];
            reg_write(10'h000, 32'(sz[0]));
            reg_write(10'h004, 32'(sz[1]));
            for (int r = 0; r < 2; r++)
                for (int p = 0; p < 1024; p++)
                    for (int ns = 0; ns < 2; ns++)
                        access(r, p, 1'(ns), 1'(p[0] ^ ns[0]));
        end
        // R5 lock-setting write also loads size; R4 lock sticky
        reg_write(10'h004, 32'h8000_0007);
        sz[1] = 7;
        reg_read_check(10'h004, 32'h8000_0007, "R5");
        reg_write(10'h004, 32'h0000_0003);
        reg_read_check(10'h004, 32'h8000_0007, "R4");
        reg_write(10'h004, 32'h8000_0200);
        reg_read_check(10'h004, 32'h8000_0007, "R5");
        // locked size still governs decisions
        for (int p = 0; p < 12; p++) access(1, p, 1'b1, 1'b0);
        // region 0 stays unlocked and writable
        reg_write(10'h000, 32'd9);
        reg_read_check(10'h000, 32'd9, "R4");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule